// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port behind an APB slave. Software sets each pin as an input or an output through a direction register. It reaches the pins through a data window in which the access address carries a per-pin mask. Because the mask travels in the address, one write can set or clear any subset of output pins without first reading the register back. One read can also isolate any subset of pins.

Each pin's output value and output enable come from registers. The pin inputs pass through a configurable chain of synchronizing flops before software can see them. A system that needs more pins places several ports side by side, and each port serves eight consecutive pin numbers.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted, and immediately after it, pinOut and pinOutEn are all zero, so every pin is an input.
- R2: A write to byte offset 0x400 loads the direction register from apbWdata[7:0]. A 1 in bit n makes pin n an output. pinOutEn always equals the direction register.
- R3: A write to an address with apbAddr[11:10] = 0 is a data write whose mask is apbAddr[9:2]. Bit n of the mask selects pin n. Each pinOut bit whose mask bit is 1 takes the matching apbWdata bit, and every other bit keeps its value.
- R4: A read from the data window returns 0 in every bit whose mask bit is 0, and returns 0 in bits 31:8.
- R5: In a data read, each selected bit of an output pin returns its pinOut register bit. Each selected bit of an input pin returns pinIn as it was two rising clock edges earlier.
- R6: A read of offset 0x400 returns the direction register in bits 7:0, with zeros above.
- R7: Offsets that are neither in the data window nor 0x400 read as 0, and writes to them change neither pinOut nor pinOutEn.
- R8: apbReady is always 1 and apbSlvErr is always 0.
- R9: Registers change only on a clock edge where apbSel, apbEnable and apbWrite are all high. A setup-phase cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| apbClk | input | 1 | APB clock |
| apbRstN | input | 1 | Asynchronous active-low reset |
| apbSel | input | 1 | Slave select |
| apbEnable | input | 1 | Access-phase flag |
| apbWrite | input | 1 | 1 = write, 0 = read |
| apbAddr | input | 12 | Byte address |
| apbWdata | input | 32 | Write data |
| apbRdata | output | 32 | Read data, valid while apbSel is high |
| apbReady | output | 1 | Always ready |
| apbSlvErr | output | 1 | Always zero |
| pinIn | input | 8 | Asynchronous pin inputs |
| pinOut | output | 8 | Pin output values |
| pinOutEn | output | 8 | Pin output enables |

## Verification
The assertions are checked on every cycle. They cover:
- the masked data-write update and the way unmasked read bits are forced to zero;
- the fact that the registers stay stable outside access-phase writes and on writes to unmapped offsets;
- the direction readback, the fixed handshake, and the reset values.

Some behaviour can be shown only by the bench's scenarios:
- the source of each read bit (the output register for outputs, the synchronized input for inputs);
- the exact two-edge latency of the input path;
- multi-step sequences of masked writes that build up a pin pattern.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic dataRd;
    logic dirRd;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PIN_W      = 8,
  parameter int DIR_OFFSET = 'h400
) (
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  output gpioStrobe_t       strobe,
  output logic [PIN_W-1:0]  accMask
);

  localparam int MASK_LSB = 2;
  localparam int MASK_MSB = MASK_LSB + PIN_W - 1;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic inDataWin;
  logic inDirReg;
  logic accWrite;

  assign inDataWin = (apbAddr[ADDR_W-1:MASK_MSB+1] == '0);
  assign inDirReg  = (apbAddr[ADDR_W-1:MASK_LSB] == DIR_ADDR[ADDR_W-1:MASK_LSB]);
  assign accWrite  = apbSel && apbEnable && apbWrite;
  assign accMask   = apbAddr[MASK_MSB:MASK_LSB];

  always_comb begin
    strobe        = '0;
    strobe.dataWr = accWrite && inDataWin;
    strobe.dirWr  = accWrite && inDirReg;
    strobe.dataRd = apbSel && !apbWrite && inDataWin;
    strobe.dirRd  = apbSel && !apbWrite && inDirReg;
  end

endmodule

// File: rtl/gpio_mask_dpath.sv
module gpio_mask_dpath
  import gpio_mask_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       strobe,
  input  logic [PIN_W-1:0]  accMask,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutEn
);

  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] outReg;
  logic [PIN_W-1:0] syncChain [SYNC_STAGES];
  logic [PIN_W-1:0] pinSync;
  logic [PIN_W-1:0] pinView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (strobe.dirWr)  dirReg <= wrData[PIN_W-1:0];
      if (strobe.dataWr) outReg <= (outReg & ~accMask) | (wrData[PIN_W-1:0] & accMask);
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= pinIn;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];

  generate
    for (genvar p = 0; p < PIN_W; p++) begin : g_view
      assign pinView[p] = dirReg[p] ? outReg[p] : pinSync[p];
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strobe.dataRd)     rdData = DATA_W'(pinView & accMask);
    else if (strobe.dirRd) rdData = DATA_W'(dirReg);
  end

  assign pinOut   = outReg;
  assign pinOutEn = dirReg;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIR_OFFSET  = 'h400
) (
  input  logic              apbClk,
  input  logic              apbRstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic [DATA_W-1:0] apbWdata,
  output logic [DATA_W-1:0] apbRdata,
  output logic              apbReady,
  output logic              apbSlvErr,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutEn
);

  gpioStrobe_t      strobe;
  logic [PIN_W-1:0] accMask;

  gpio_mask_ctrl #(
    .ADDR_W(ADDR_W), .PIN_W(PIN_W), .DIR_OFFSET(DIR_OFFSET)
  ) u_ctrl (
    .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbAddr(apbAddr), .strobe(strobe), .accMask(accMask)
  );

  gpio_mask_dpath #(
    .PIN_W(PIN_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(apbClk), .rstN(apbRstN), .strobe(strobe), .accMask(accMask),
    .wrData(apbWdata), .pinIn(pinIn), .rdData(apbRdata),
    .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

  assign apbReady  = 1'b1;
  assign apbSlvErr = 1'b0;

endmodule

// File: rtl/gpio_mask_sva.sv
module gpio_mask_sva #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int PIN_W      = 8,
  parameter int DIR_OFFSET = 'h400
) (
  input logic              apbClk,
  input logic              apbRstN,
  input logic              apbSel,
  input logic              apbEnable,
  input logic              apbWrite,
  input logic [ADDR_W-1:0] apbAddr,
  input logic [DATA_W-1:0] apbWdata,
  input logic [DATA_W-1:0] apbRdata,
  input logic              apbReady,
  input logic              apbSlvErr,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOutEn
);

  localparam int MSB = PIN_W + 1;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic             chkWin, chkDir, chkWr;
  logic [PIN_W-1:0] chkMask;

  assign chkWin  = (apbAddr[ADDR_W-1:MSB+1] == '0);
  assign chkDir  = (apbAddr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
  assign chkWr   = apbSel && apbEnable && apbWrite;
  assign chkMask = apbAddr[MSB:2];

  // R1: reset forces outputs to zero
  assert_reset_clear_R1: assert property (@(posedge apbClk)
    !apbRstN |-> (pinOut == '0 && pinOutEn == '0));

  assert_dir_readback_R6: assert property (@(posedge apbClk) disable iff (!apbRstN)
    (apbSel && !apbWrite && chkDir) |-> (apbRdata == DATA_W'(pinOutEn)));

  assert_masked_write_R3: assert property (@(posedge apbClk) disable iff (!apbRstN)
    (chkWr && chkWin) |=> (pinOut == (($past(pinOut) & ~$past(chkMask)) |
                                      ($past(apbWdata[PIN_W-1:0]) & $past(chkMask)))));

  assert_read_masked_R4: assert property (@(posedge apbClk) disable iff (!apbRstN)
    (apbSel && !apbWrite && chkWin) |-> ((apbRdata & ~DATA_W'(chkMask)) == '0));

  assert_unmapped_R7: assert property (@(posedge apbClk) disable iff (!apbRstN)
    (chkWr && !chkWin && !chkDir) |=> ($stable(pinOut) && $stable(pinOutEn)));

  assert_unmapped_read_R7: assert property (@(posedge apbClk) disable iff (!apbRstN)
    (apbSel && !apbWrite && !chkWin && !chkDir) |-> (apbRdata == '0));

  assert_no_write_R9: assert property (@(posedge apbClk) disable iff (!apbRstN)
    !chkWr |=> ($stable(pinOut) && $stable(pinOutEn)));

  assert_handshake_R8: assert property (@(posedge apbClk) disable iff (!apbRstN)
    (apbReady && !apbSlvErr));

endmodule

bind gpio_mask_port gpio_mask_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W), .DIR_OFFSET(DIR_OFFSET)
) u_sva (
  .apbClk(apbClk), .apbRstN(apbRstN), .apbSel(apbSel), .apbEnable(apbEnable),
  .apbWrite(apbWrite), .apbAddr(apbAddr), .apbWdata(apbWdata),
  .apbRdata(apbRdata), .apbReady(apbReady), .apbSlvErr(apbSlvErr),
  .pinOut(pinOut), .pinOutEn(pinOutEn)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic [7:0]  expOut;
    logic [7:0]  expOe;
  } vec_t;

  // pinIn held at 8'hA5 during the table
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h400, 32'h0,  32'h00, 8'h00, 8'h00}, // R6 reset dir
    '{1'b1, 12'h400, 32'h0F, 32'h00, 8'h00, 8'h0F}, // R2
    '{1'b1, 12'h3FC, 32'h3C, 32'h00, 8'h3C, 8'h0F}, // R3 full mask
    '{1'b0, 12'h3FC, 32'h0,  32'hAC, 8'h3C, 8'h0F}, // R5 mixed sources
    '{1'b1, 12'h004, 32'h01, 32'h00, 8'h3D, 8'h0F}, // R3 set pin0
    '{1'b1, 12'h010, 32'h00, 32'h00, 8'h39, 8'h0F}, // R3 clear pin2
    '{1'b1, 12'h030, 32'hFF, 32'h00, 8'h3D, 8'h0F}, // R3 two bits
    '{1'b1, 12'h000, 32'hFF, 32'h00, 8'h3D, 8'h0F}, // R3 empty mask
    '{1'b0, 12'h3C0, 32'h0,  32'hA0, 8'h3D, 8'h0F}, // R4 high nibble
    '{1'b0, 12'h00C, 32'h0,  32'h01, 8'h3D, 8'h0F}, // R4 low two bits
    '{1'b1, 12'h800, 32'hFF, 32'h00, 8'h3D, 8'h0F}, // R7 write ignored
    '{1'b0, 12'h800, 32'h0,  32'h00, 8'h3D, 8'h0F}, // R7 read zero
    '{1'b0, 12'h404, 32'h0,  32'h00, 8'h3D, 8'h0F}, // R7 read zero
    '{1'b1, 12'h404, 32'hFF, 32'h00, 8'h3D, 8'h0F}, // R7 write ignored
    '{1'b0, 12'h400, 32'h0,  32'h0F, 8'h3D, 8'h0F}, // R6
    '{1'b1, 12'h400, 32'hF0, 32'h00, 8'h3D, 8'hF0}, // R2
    '{1'b0, 12'h3FC, 32'h0,  32'h35, 8'h3D, 8'hF0}  // R5
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        sel = 0, en = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, slvErr;
  logic [7:0]  pinIn = 8'hA5;
  logic [7:0]  pinOut, pinOutEn;
  int          nChecks = 0, nFails = 0;
  logic        done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_port u_gpio_mask_port (
    .apbClk(clk), .apbRstN(rstN), .apbSel(sel), .apbEnable(en), .apbWrite(wr),
    .apbAddr(addr), .apbWdata(wdata), .apbRdata(rdata), .apbReady(ready),
    .apbSlvErr(slvErr), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one APB transfer; returns read data sampled in the access phase
  task automatic apbXfer(input logic isWr, input logic [11:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    @(negedge clk);
    sel = 1; en = 0; wr = isWr; addr = a; wdata = d;
    @(negedge clk);
    en = 1;
    #1 rd = rdata;
    @(negedge clk);
    sel = 0; en = 0; wr = 0;
    #1;
  endtask

  initial begin
    logic [31:0] rd;
    #(3*CLK_PERIOD);
    check("R1 out", {24'b0, pinOut}, 32'h0);
    check("R1 oe", {24'b0, pinOutEn}, 32'h0);
    check("R8", {30'b0, ready, slvErr}, 32'h2);
    @(negedge clk) rstN = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      apbXfer(VECS[i].isWr, VECS[i].addr, VECS[i].wdata, rd);
      if (!VECS[i].isWr) check($sformatf("R4/R5/R6/R7 rd vec%0d", i), rd, VECS[i].expRd);
      check($sformatf("R3/R7 out vec%0d", i), {24'b0, pinOut}, {24'b0, VECS[i].expOut});
      check($sformatf("R2 oe vec%0d", i), {24'b0, pinOutEn}, {24'b0, VECS[i].expOe});
    end

    // R9: setup phase only, then drop without access phase
    @(negedge clk);
    sel = 1; en = 0; wr = 1; addr = 12'h3FC; wdata = 32'h00;
    @(negedge clk);
    sel = 1; en = 0; wr = 1; addr = 12'h400; wdata = 32'hFF;
    @(negedge clk);
    sel = 0; wr = 0;
    #1;
    check("R9 out", {24'b0, pinOut}, 32'h3D);
    check("R9 oe", {24'b0, pinOutEn}, 32'hF0);

    // R5: two-edge input latency, read of low nibble inputs held selected
    @(negedge clk);
    sel = 1; en = 0; wr = 0; addr = 12'h03C;
    pinIn = 8'h5A;
    #1 check("R5 before edge", rdata, 32'h05);
    @(negedge clk);
    #1 check("R5 after one edge", rdata, 32'h05);
    @(negedge clk);
    #1 check("R5 after two edges", rdata, 32'h0A);
    sel = 0;

    check("R8 again", {30'b0, ready, slvErr}, 32'h2);

    // R1: reset in mid-run
    @(negedge clk) rstN = 0;
    #1;
    check("R1 mid out", {24'b0, pinOut}, 32'h0);
    check("R1 mid oe", {24'b0, pinOutEn}, 32'h0);
    @(negedge clk) rstN = 1;
    apbXfer(1'b0, 12'h400, 32'h0, rd);
    check("R1 dir after reset", rd, 32'h0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule